// File: doc/BRIEF.md
# SPI master shift engine

This block is a full-duplex SPI master that moves one 8-bit character per transfer. The host first loads a single data register. It then starts a transfer, waits for the completion flag and reads the same register back. By then the register holds the byte clocked in from MISO in place of the byte that went out on MOSI. Clock polarity and clock phase are selected per transfer. The SCK rate comes from a programmable divider of the system clock.

Slave select is driven by the block. It falls half an SCK period before the first clock transition and rises half a period after the last one. When the phase input is 0, slave select is forced high for at least one full SCK period after every character. When the phase input is 1, the next start may be issued in the half period that follows the last edge, and slave select then stays low across back-to-back characters.

Top module: `spi_xfer_engine`

## Requirements
- R1: With slave select high, SCK rests at the level of `cpol` (0: low, 1: high). Every character produces exactly 16 SCK transitions, and SCK is back at its resting level after the last one.
- R2: Consecutive SCK transitions are `clk_div`+1 system cycles apart, so one SCK period is 2×(`clk_div`+1) cycles, for any 8-bit `clk_div`.
- R3: Bits travel most significant first in both directions at once. MISO is sampled on the rising SCK edge when `cpol` equals `cpha` and on the falling edge otherwise. MOSI changes only on the opposite edge. After the character, `rd_data` holds the received byte.
- R4: With `cpha`=0, bit 7 of the data register is on MOSI from the first cycle in which `ss_n` is low.
- R5: `ss_n` falls `clk_div`+1 cycles before the first SCK transition. For a character not followed by a back-to-back start, it rises `clk_div`+1 cycles after the last transition.
- R6: With `cpha`=0, `ss_n` stays high for at least 2×(`clk_div`+1) cycles after each character. A start or a write during that interval is ignored: `done` stays set and the register is unchanged.
- R7: With `cpha`=1, a start (optionally with a same-cycle write, which is then the byte sent) is accepted while `done` is set in the half period after the last edge. The next character then follows with `ss_n` held low throughout.
- R8: `done` rises in the cycle of the SCK transition that carries the eighth sample. This is the 15th transition when `cpha`=0 and the 16th when `cpha`=1.
- R9: `done`, once set, stays set until a cycle with `rd_en` high or an accepted start clears it.
- R10: While a character is being shifted, `wr_en` and `start` have no effect on the bytes exchanged, on `rd_data` or on `done`.
- R11: After reset, `ss_n` is 1, `done` is 0, `rd_data` is 0 and SCK rests at the `cpol` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK resting level |
| cpha | input | 1 | Clock phase select |
| clk_div | input | 8 | Half-period length minus one, in system cycles |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to load |
| start | input | 1 | Begin a character |
| rd_en | input | 1 | Host read of the data register; clears `done` |
| rd_data | output | 8 | Data register (byte to send, then byte received) |
| done | output | 1 | Transfer-complete flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
A corrupted edge index shows up as a character with the wrong number of SCK transitions, or as SCK stuck at the wrong level once slave select rises. In either case it is visible by the end of that same character. A wrong divider count is visible at the very first SCK transition, which arrives at the wrong distance from the fall of slave select. A fault in the shift path or in the sample-edge choice changes the received byte seen on `rd_data`, or the byte the bench's slave collects, as soon as `done` rises. A fault in the phase sequencing shows as a missing gap or an unwanted gap in `ss_n` between two characters.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

    localparam int EDGE_CNT_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_SHIFT = 3'd2,
        PH_HOLD  = 3'd3,
        PH_GAP   = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e                  ph;
        logic [EDGE_CNT_W-1:0]   eidx;
        logic                    lvl;
        logic                    flag;
        logic                    gap2;
    } ctl_s;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && !restart && (cnt_q >= div);
        cnt_d = cnt_q + 1'b1;
        if (!run || restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: each half period starts counting again from zero
    a_r2_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sample_en,
    input  logic         change_en,
    input  logic         miso,
    output logic [W-1:0] data_o,
    output logic         mosi_o
);
    logic [W-1:0] sh_d, sh_q;
    logic         mo_d, mo_q;

    always_comb begin
        sh_d = sh_q;
        mo_d = mo_q;
        if (load) begin
            sh_d = load_val;
            mo_d = load_val[W-1];
        end else begin
            if (sample_en) sh_d = {sh_q[W-2:0], miso};
            if (change_en) mo_d = sh_q[W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            mo_q <= 1'b0;
        end else begin
            sh_q <= sh_d;
            mo_q <= mo_d;
        end
    end

    assign data_o = sh_q;
    assign mosi_o = mo_q;

    // R3: a sampling edge stores the MISO level into the low bit
    a_r3_sample_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !load) |=> (data_o[0] == $past(miso)));

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_mst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    localparam int                    EDGES     = 2 * DATA_W;
    localparam logic [EDGE_CNT_W-1:0] LAST_EDGE = EDGE_CNT_W'(EDGES - 1);
    localparam logic [EDGE_CNT_W-1:0] LAST_SMP0 = EDGE_CNT_W'(EDGES - 2);

    ctl_s              ctl_d, ctl_q;
    logic              tick, accept, wr_ok, start_ok;
    logic              edge_stb, smp_stb, chg_stb, last_smp, load;
    logic [DATA_W-1:0] load_val;

    always_comb begin
        accept   = (ctl_q.ph == PH_IDLE) || (ctl_q.ph == PH_HOLD && cpha);
        wr_ok    = wr_en && accept;
        start_ok = start && accept;
        edge_stb = tick && (ctl_q.ph == PH_SETUP || ctl_q.ph == PH_SHIFT);
        smp_stb  = edge_stb && (ctl_q.eidx[0] == cpha);
        chg_stb  = edge_stb && !smp_stb && (ctl_q.eidx != LAST_EDGE);
        last_smp = smp_stb && (ctl_q.eidx == (cpha ? LAST_EDGE : LAST_SMP0));
        load     = wr_ok || start_ok;
        load_val = wr_ok ? wr_data : rd_data;

        ctl_d = ctl_q;
        if (edge_stb) begin
            ctl_d.lvl  = !ctl_q.lvl;
            ctl_d.eidx = ctl_q.eidx + 1'b1;
        end
        case (ctl_q.ph)
            PH_IDLE: begin
                if (start_ok) begin
                    ctl_d.ph   = PH_SETUP;
                    ctl_d.eidx = '0;
                end
            end
            PH_SETUP: begin
                if (tick) ctl_d.ph = PH_SHIFT;
            end
            PH_SHIFT: begin
                if (tick && ctl_q.eidx == LAST_EDGE) ctl_d.ph = PH_HOLD;
            end
            PH_HOLD: begin
                if (start_ok) begin
                    ctl_d.ph   = PH_SETUP;
                    ctl_d.eidx = '0;
                end else if (tick) begin
                    ctl_d.ph   = cpha ? PH_IDLE : PH_GAP;
                    ctl_d.gap2 = 1'b0;
                end
            end
            PH_GAP: begin
                if (tick) begin
                    if (ctl_q.gap2) ctl_d.ph = PH_IDLE;
                    else            ctl_d.gap2 = 1'b1;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase

        if (last_smp)                ctl_d.flag = 1'b1;
        else if (rd_en || start_ok)  ctl_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= ctl_s'('0);
        else        ctl_q <= ctl_d;
    end

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_q.ph != PH_IDLE),
        .restart (start_ok),
        .div     (clk_div),
        .tick    (tick)
    );

    spi_shift_reg #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (load_val),
        .sample_en (smp_stb),
        .change_en (chg_stb),
        .miso      (miso),
        .data_o    (rd_data),
        .mosi_o    (mosi)
    );

    assign sck  = cpol ^ ctl_q.lvl;
    assign ss_n = (ctl_q.ph == PH_IDLE) || (ctl_q.ph == PH_GAP);
    assign done = ctl_q.flag;

    // R1: resting SCK level whenever no character is running
    a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_IDLE) |-> (sck == cpol));

    // R1: after the final transition SCK is back at rest
    a_r1_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_HOLD) |-> (sck == cpol));

    // R6: select stays released through the inter-character gap
    a_r6_gap_ss_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_GAP) |-> ss_n);

    // R8: the flag only rises on the eighth sample
    a_r8_flag_on_last_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(last_smp));

    // R10: between sample edges the register is untouched by host writes
    a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_SHIFT && !smp_stb) |=> (rd_data == $past(rd_data)));

endmodule

// File: tb/spi_xfer_engine_test.sv
`timescale 1ns/1ps
module spi_xfer_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0;
    logic [7:0] clk_div = 8'd0;
    logic       wr_en = 1'b0, start = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       done, sck, mosi, ss_n;
    logic       miso = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spi_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .clk_div(clk_div),
        .wr_en(wr_en), .wr_data(wr_data), .start(start), .rd_en(rd_en),
        .rd_data(rd_data), .done(done), .sck(sck), .mosi(mosi), .miso(miso),
        .ss_n(ss_n)
    );

    // behavioural slave
    logic [7:0] slv_tx = 8'd0, slv_rx = 8'd0;
    logic       sck_seen = 1'b0, ss_seen = 1'b1;
    always @(sck or ss_n) begin
        if (ss_n !== ss_seen) begin
            if (ss_n === 1'b0) begin
                slv_rx = 8'd0;
                if (!cpha) begin
                    miso   = slv_tx[7];
                    slv_tx = {slv_tx[6:0], 1'b0};
                end
            end
            ss_seen = ss_n;
        end else if (sck !== sck_seen && ss_n === 1'b0) begin
            if (sck === (cpol == cpha)) begin
                slv_rx = {slv_rx[6:0], mosi};
            end else begin
                miso   = slv_tx[7];
                slv_tx = {slv_tx[6:0], 1'b0};
            end
        end
        sck_seen = sck;
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        case (k % 6)
            0:       return 8'h00;
            1:       return 8'hFF;
            2:       return 8'hA5;
            3:       return 8'h01;
            4:       return 8'h80;
            default: return 8'h3C;
        endcase
    endfunction

    task automatic release_char(input int dv);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk_eq("R9 done cleared by read", done, 0);
        repeat (2 * (dv + 1) + 2) @(negedge clk);
    endtask

    task automatic one_char(input logic pol, input logic ph, input int dv,
                            input logic [7:0] mb, input logic [7:0] sb, input bit poke);
        int   cyc, edges, first, last, bad_gap, done_edge, ss_rise;
        logic prev_sck, prev_done;
        bit   poked;
        cpol = pol; cpha = ph; clk_div = 8'(dv);
        @(negedge clk);
        chk_eq("R1 resting level", sck, pol);
        wr_en = 1'b1; wr_data = mb;
        @(negedge clk); wr_en = 1'b0;
        slv_tx = sb; slv_rx = 8'd0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk_eq("R5 select low after start", ss_n, 0);
        if (!ph) chk_eq("R4 MSB on MOSI at select", mosi, mb[7]);
        cyc = 0; edges = 0; first = -1; last = 0; bad_gap = 0;
        done_edge = -1; ss_rise = -1; prev_sck = sck; prev_done = done; poked = 0;
        while (ss_rise < 0 && cyc < 20000) begin
            @(negedge clk); cyc++;
            if (poked) begin wr_en = 1'b0; start = 1'b0; end
            if (sck !== prev_sck) begin
                edges++;
                if (first < 0) first = cyc;
                else if (cyc - last != dv + 1) bad_gap++;
                last = cyc;
            end
            prev_sck = sck;
            if (done && !prev_done) done_edge = edges;
            prev_done = done;
            if (ss_n) ss_rise = cyc;
            if (poke && edges == 5 && !poked) begin
                wr_en = 1'b1; wr_data = ~mb; start = 1'b1; poked = 1;
            end
        end
        chk_eq("R1 transitions per character", edges, 16);
        chk_eq("R1 level after character", sck, pol);
        chk_eq("R2 irregular half periods", bad_gap, 0);
        chk_eq("R5 select-to-first-edge cycles", first, dv + 1);
        chk_eq("R5 last-edge-to-release cycles", ss_rise - last, dv + 1);
        chk_eq("R8 transition count at done", done_edge, ph ? 16 : 15);
        chk_eq("R3 received byte in register", rd_data, sb);
        chk_eq("R3 byte seen by slave", slv_rx, mb);
        chk_eq("R9 done held until read", done, 1);
        if (poke) chk_eq("R10 busy write/start ignored", rd_data, sb);
        release_char(dv);
    endtask

    task automatic gap_test(input logic pol, input int dv, input logic [7:0] mb,
                            input logic [7:0] sb1, input logic [7:0] sb2);
        int hcnt, guard, lost;
        cpol = pol; cpha = 1'b0; clk_div = 8'(dv);
        @(negedge clk); wr_en = 1'b1; wr_data = mb;
        @(negedge clk); wr_en = 1'b0;
        slv_tx = sb1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        guard = 0;
        while (!ss_n && guard < 20000) begin @(negedge clk); guard++; end
        // first cycle of the gap
        start = 1'b1; wr_en = 1'b1; wr_data = 8'hEE; slv_tx = sb2;
        hcnt = 1; lost = 0;
        @(negedge clk); wr_en = 1'b0;
        while (ss_n && hcnt < 20000) begin
            if (!done) lost++;
            hcnt++;
            @(negedge clk);
        end
        start = 1'b0;
        chk_eq("R6 gap not shorter than one SCK period", (hcnt >= 2 * (dv + 1)) ? 1 : 0, 1);
        chk_eq("R6 gap not longer than needed", (hcnt <= 2 * (dv + 1) + 1) ? 1 : 0, 1);
        chk_eq("R6 start in gap left done set", lost, 0);
        guard = 0;
        while (!done && guard < 20000) begin @(negedge clk); guard++; end
        chk_eq("R6 write in gap ignored", slv_rx, sb1);
        chk_eq("R3 second received byte", rd_data, sb2);
        guard = 0;
        while (!ss_n && guard < 20000) begin @(negedge clk); guard++; end
        release_char(dv);
    endtask

    task automatic b2b_test(input logic pol, input int dv, input logic [7:0] mb1,
                            input logic [7:0] sb1, input logic [7:0] mb2,
                            input logic [7:0] sb2);
        int guard, hi_seen;
        cpol = pol; cpha = 1'b1; clk_div = 8'(dv);
        @(negedge clk); wr_en = 1'b1; wr_data = mb1;
        @(negedge clk); wr_en = 1'b0;
        slv_tx = sb1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        guard = 0;
        while (!done && guard < 20000) begin @(negedge clk); guard++; end
        chk_eq("R3 first received byte", rd_data, sb1);
        chk_eq("R3 first byte at slave", slv_rx, mb1);
        wr_en = 1'b1; wr_data = mb2; start = 1'b1;
        slv_tx = sb2; slv_rx = 8'd0;
        @(negedge clk); wr_en = 1'b0; start = 1'b0;
        chk_eq("R9 accepted start clears done", done, 0);
        hi_seen = 0; guard = 0;
        while (!done && guard < 20000) begin
            if (ss_n) hi_seen++;
            @(negedge clk); guard++;
        end
        chk_eq("R7 select held low back-to-back", hi_seen, 0);
        chk_eq("R7 second received byte", rd_data, sb2);
        chk_eq("R7 second byte at slave", slv_rx, mb2);
        guard = 0;
        while (!ss_n && guard < 20000) begin @(negedge clk); guard++; end
        release_char(dv);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk_eq("R11 select idle after reset", ss_n, 1);
        chk_eq("R11 done clear after reset", done, 0);
        chk_eq("R11 register clear after reset", rd_data, 0);
        chk_eq("R11 SCK at rest after reset", sck, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int m = 0; m < 4; m++)
            for (int dv = 0; dv < 3; dv++)
                for (int k = 0; k < 6; k++)
                    one_char(m[1], m[0], dv, pat(k), pat(k + 3) ^ 8'(dv + m), k == 2);

        for (int i = 0; i < 256; i++)
            one_char(1'b0, 1'b0, 0, 8'(i), ~8'(i) ^ 8'h5A, 1'b0);
        for (int i = 0; i < 256; i++)
            one_char(1'b1, 1'b1, 0, 8'(i), 8'(i * 37 + 11), 1'b0);

        one_char(1'b0, 1'b1, 255, 8'hC3, 8'h5E, 1'b1);

        for (int dv = 0; dv < 4; dv++) begin
            gap_test(1'b0, dv, 8'h96, 8'h4B, 8'hD2);
            gap_test(1'b1, dv, 8'h0F, 8'hF0, 8'h81);
        end
        for (int dv = 0; dv < 3; dv++) begin
            b2b_test(1'b0, dv, 8'hA1, 8'h1A, 8'h7E, 8'hE7);
            b2b_test(1'b1, dv, 8'h55, 8'hAA, 8'h00, 8'hFF);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule